// File: doc/BRIEF.md
# SPI Response Packetizer with Replay

This block sits between an SPI transfer engine and a USB bulk-in endpoint. When the engine reports a finished transfer, with a 16-bit status and a read length, the block turns the result into device-to-host packets. The first packet opens the response and carries the status and up to 60 read bytes. Each later continuation packet carries up to 60 more bytes, tagged with the number of read bytes already sent. Read bytes are fetched from an external buffer through a combinational address/data port.

The block also decodes host commands that arrive as an already-parsed identifier plus a 16-bit argument. A replay command rewinds the stored response and sends it again from the opening packet without a new SPI transfer. A new-transfer command drops whatever is left of the pending response. A configuration query is answered with the buffer limits and a feature word. A chip-select command drives a select output and is acknowledged. Packets leave as a byte stream with valid, last and ready. The bytes of one packet are never interleaved with another packet.

Top module: `rsp_packetizer`

## Requirements
- R1: An opening response packet is the bytes 0x05, 0x00, status low, status high. These are followed by min(60, E) read bytes taken from buffer addresses 0 upward. E is the effective read length. `out_last` is high on the final byte only.
- R2: While bytes remain, continuation packets follow: 0x06, 0x00, index low, index high, then min(60, remaining) bytes starting at buffer address index. The index is the count of read bytes already sent. E = 0 gives a single 4-byte opening packet. A read length above MAX_RD is treated as MAX_RD.
- R3: A non-zero status forces E = 0, so the response is one 4-byte opening packet whatever the read length.
- R4: Command identifier 4 (replay) takes effect when the packet in flight ends. Emission then restarts at the opening packet with identical contents. Replay is ignored when no response has been captured since reset or since the last abandon.
- R5: Command identifier 2 (new transfer) abandons the stored response. The packet in flight completes, and no further response packet is sent.
- R6: Command identifier 0 is answered with an 8-byte packet: 0x01, 0x00, MAX_WR, MAX_RD and FEATURES. Each of the three values is 16 bits, sent low byte first.
- R7: Command identifier 7 with argument 0 or 1 sets `cs_active` to that value and is answered 0x08, 0x00, 0x00, 0x00. Any other argument leaves `cs_active` unchanged and is answered 0x08, 0x00, 0x01, 0x00.
- R8: At a packet boundary, a pending chip-select reply goes first, then a configuration reply, then response packets.
- R9: A byte advances only when `out_valid` and `out_ready` are both high. While stalled, `out_data` and `out_last` stay stable. `out_valid` never drops inside a packet.
- R10: A new result arriving during a response lets the packet in flight finish. The new response then starts from its opening packet.
- R11: After reset, `out_valid` and `cs_active` are low and nothing is pending.
- R12: Command identifiers other than 0, 2, 4 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | One-cycle pulse: SPI transfer result available |
| res_status | input | 16 | Transfer status, 0 means success |
| res_len | input | 16 | Number of read bytes in the buffer |
| rd_addr | output | ADDRW | Read-buffer byte address |
| rd_data | input | 8 | Read-buffer byte at `rd_addr` (same cycle) |
| cmd_valid | input | 1 | One-cycle pulse: host command decoded |
| cmd_id | input | 16 | Host packet identifier |
| cmd_arg | input | 16 | Command argument (chip-select action) |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of a packet |
| out_ready | input | 1 | Sink accepts the byte |
| cs_active | output | 1 | Chip-select request state |

## Verification
The hardest case to reach is a command that lands in the middle of a response packet. The replay, abandon, priority and new-result cases all depend on it. Commands that arrive in the middle of a packet must be deferred, and a packet made stale must not corrupt the offset. The bench forks a command thread next to the packet collector and fires the command a fixed number of cycles after the result. The sink stalls every fifth cycle, so the opening packet is certain to still be in flight. A sweep of every read length from 0 to 130, plus the MAX_RD edge and an oversize length, checks every chunk split arithmetically.

// File: rtl/rsp_pkt_pkg.sv
package rsp_pkt_pkg;

    localparam int CHUNK_MAX = 60;
    localparam int HDR_BYTES = 4;

    localparam logic [15:0] ID_CFG_QUERY = 16'd0;
    localparam logic [15:0] ID_NEW_XFER  = 16'd2;
    localparam logic [15:0] ID_REPLAY    = 16'd4;
    localparam logic [15:0] ID_CS_CMD    = 16'd7;

    typedef enum logic [1:0] {
        PK_CS    = 2'd0,
        PK_CFG   = 2'd1,
        PK_START = 2'd2,
        PK_CONT  = 2'd3
    } pkt_kind_e;

    typedef enum logic {
        EM_IDLE = 1'b0,
        EM_SEND = 1'b1
    } em_state_e;

    typedef struct packed {
        pkt_kind_e   kind;
        logic [6:0]  plen;
        logic [15:0] field;
    } pkt_desc_t;

    function automatic logic [7:0] kind_id(input pkt_kind_e k);
        case (k)
            PK_CS:    return 8'd8;
            PK_CFG:   return 8'd1;
            PK_START: return 8'd5;
            default:  return 8'd6;
        endcase
    endfunction

    function automatic logic [15:0] chunk_of(input logic [15:0] remain);
        return (remain > 16'(CHUNK_MAX)) ? 16'(CHUNK_MAX) : remain;
    endfunction

endpackage

// File: rtl/rsp_cmd_decode.sv
module rsp_cmd_decode
    import rsp_pkt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [15:0] cmd_id,
    input  logic [15:0] cmd_arg,
    input  logic        res_valid,
    input  logic        take_cs,
    input  logic        take_cfg,
    input  logic        take_restart,
    output logic        cs_req,
    output logic        cfg_req,
    output logic        restart_req,
    output logic        abandon,
    output logic [15:0] cs_status,
    output logic        cs_active
);

    assign abandon = cmd_valid && (cmd_id == ID_NEW_XFER);

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_req      <= 1'b0;
            cfg_req     <= 1'b0;
            restart_req <= 1'b0;
            cs_status   <= '0;
            cs_active   <= 1'b0;
        end else begin
            if (take_cs)      cs_req      <= 1'b0;
            if (take_cfg)     cfg_req     <= 1'b0;
            if (take_restart) restart_req <= 1'b0;
            if (res_valid)    restart_req <= 1'b0;
            if (cmd_valid) begin
                case (cmd_id)
                    ID_CS_CMD: begin
                        cs_req <= 1'b1;
                        if (cmd_arg <= 16'd1) begin
                            cs_active <= cmd_arg[0];
                            cs_status <= 16'd0;
                        end else begin
                            cs_status <= 16'd1;
                        end
                    end
                    ID_CFG_QUERY: cfg_req     <= 1'b1;
                    ID_REPLAY:    restart_req <= 1'b1;
                    ID_NEW_XFER:  restart_req <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

    // R7: a valid assert action raises the select output
    p_cs_assert_r7: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_id == ID_CS_CMD && cmd_arg == 16'd1 |=> cs_active);

    // R7: an out-of-range action leaves the select output alone
    p_cs_keep_r7: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_id == ID_CS_CMD && cmd_arg > 16'd1 |=> $stable(cs_active));

    // R12: unknown identifiers raise no request
    p_unknown_r12: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_id != ID_CS_CMD && cmd_id != ID_CFG_QUERY && !cs_req && !cfg_req
        |=> !cs_req && !cfg_req);

endmodule

// File: rtl/rsp_track.sv
module rsp_track
    import rsp_pkt_pkg::*;
#(
    parameter int MAX_RD = 298
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        res_valid,
    input  logic [15:0] res_status,
    input  logic [15:0] res_len,
    input  logic        abandon,
    input  logic        apply_restart,
    input  logic        launch,
    input  logic        done,
    output logic        active,
    output logic        first,
    output logic [15:0] off,
    output logic [15:0] status,
    output logic [15:0] chunk
);

    localparam logic [15:0] RD_LIMIT = 16'(MAX_RD);

    logic        stored;
    logic        in_flight;
    logic        stale;
    logic [15:0] eff_len;
    logic [15:0] next_off;
    logic        flight_now;

    assign chunk      = chunk_of(eff_len - off);
    assign next_off   = off + chunk;
    assign flight_now = (in_flight || launch) && !done;

    always_ff @(posedge clk) begin
        if (rst) begin
            stored    <= 1'b0;
            active    <= 1'b0;
            first     <= 1'b0;
            off       <= '0;
            status    <= '0;
            eff_len   <= '0;
            in_flight <= 1'b0;
            stale     <= 1'b0;
        end else begin
            if (launch) begin
                in_flight <= 1'b1;
                stale     <= 1'b0;
            end
            if (done) begin
                in_flight <= 1'b0;
                if (!stale) begin
                    first <= 1'b0;
                    off   <= next_off;
                    if (next_off >= eff_len) active <= 1'b0;
                end
            end
            if (apply_restart && stored) begin
                active <= 1'b1;
                first  <= 1'b1;
                off    <= '0;
            end
            if (abandon) begin
                active <= 1'b0;
                stored <= 1'b0;
                if (flight_now) stale <= 1'b1;
            end
            if (res_valid) begin
                stored  <= 1'b1;
                active  <= 1'b1;
                first   <= 1'b1;
                off     <= '0;
                status  <= res_status;
                eff_len <= (res_status != 16'd0) ? 16'd0 :
                           ((res_len > RD_LIMIT) ? RD_LIMIT : res_len);
                if (flight_now) stale <= 1'b1;
            end
        end
    end

    // R2: the running index never passes the effective length
    p_off_bound_r2: assert property (@(posedge clk) disable iff (rst)
        off <= eff_len);

    // R3: an error response never carries read bytes
    p_err_empty_r3: assert property (@(posedge clk) disable iff (rst)
        launch && status != 16'd0 |-> chunk == 16'd0);

    // R4: replay rewinds to the opening packet
    p_replay_r4: assert property (@(posedge clk) disable iff (rst)
        apply_restart && stored && !abandon |=> first && active && off == 16'd0);

    // R5: abandon leaves nothing to send
    p_abandon_r5: assert property (@(posedge clk) disable iff (rst)
        abandon && !res_valid |=> !active);

endmodule

// File: rtl/rsp_emit.sv
module rsp_emit
    import rsp_pkt_pkg::*;
#(
    parameter int          MAX_WR   = 298,
    parameter int          MAX_RD   = 298,
    parameter logic [15:0] FEATURES = 16'h0001,
    parameter int          ADDRW    = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_req,
    input  logic             cfg_req,
    input  logic             restart_req,
    input  logic [15:0]      cs_status,
    input  logic             active,
    input  logic             first,
    input  logic [15:0]      off,
    input  logic [15:0]      status,
    input  logic [15:0]      chunk,
    input  logic             out_ready,
    input  logic [7:0]       rd_data,
    output logic             take_cs,
    output logic             take_cfg,
    output logic             take_restart,
    output logic             launch,
    output logic             done,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_last,
    output logic [ADDRW-1:0] rd_addr
);

    localparam logic [15:0] WR_LIMIT = 16'(MAX_WR);
    localparam logic [15:0] RD_LIMIT = 16'(MAX_RD);

    em_state_e        state;
    pkt_desc_t        desc;
    pkt_desc_t        nxt;
    logic [6:0]       bidx;
    logic [ADDRW-1:0] pkt_off;
    logic             is_resp;
    logic             at_end;

    always_comb begin
        take_cs      = 1'b0;
        take_cfg     = 1'b0;
        take_restart = 1'b0;
        launch       = 1'b0;
        nxt          = '0;
        if (state == EM_IDLE) begin
            if (cs_req) begin
                take_cs = 1'b1;
                nxt     = '{kind: PK_CS, plen: 7'd4, field: cs_status};
            end else if (cfg_req) begin
                take_cfg = 1'b1;
                nxt      = '{kind: PK_CFG, plen: 7'd8, field: WR_LIMIT};
            end else if (restart_req) begin
                take_restart = 1'b1;
            end else if (active) begin
                launch = 1'b1;
                nxt    = '{kind:  first ? PK_START : PK_CONT,
                           plen:  7'(16'(HDR_BYTES) + chunk),
                           field: first ? status : off};
            end
        end
    end

    assign out_valid = (state == EM_SEND);
    assign at_end    = (bidx == 7'(desc.plen - 7'd1));
    assign out_last  = out_valid && at_end;
    assign is_resp   = (desc.kind == PK_START) || (desc.kind == PK_CONT);
    assign done      = out_valid && out_ready && at_end && is_resp;
    assign rd_addr   = pkt_off + ADDRW'(bidx) - ADDRW'(HDR_BYTES);

    always_comb begin
        case (bidx)
            7'd0: out_data = kind_id(desc.kind);
            7'd1: out_data = 8'h00;
            7'd2: out_data = desc.field[7:0];
            7'd3: out_data = desc.field[15:8];
            default: begin
                if (desc.kind == PK_CFG) begin
                    case (bidx)
                        7'd4:    out_data = RD_LIMIT[7:0];
                        7'd5:    out_data = RD_LIMIT[15:8];
                        7'd6:    out_data = FEATURES[7:0];
                        default: out_data = FEATURES[15:8];
                    endcase
                end else begin
                    out_data = rd_data;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= EM_IDLE;
            desc    <= '0;
            bidx    <= '0;
            pkt_off <= '0;
        end else begin
            case (state)
                EM_IDLE: begin
                    if (take_cs || take_cfg || launch) begin
                        state   <= EM_SEND;
                        desc    <= nxt;
                        bidx    <= '0;
                        pkt_off <= off[ADDRW-1:0];
                    end
                end
                default: begin
                    if (out_ready) begin
                        if (at_end) state <= EM_IDLE;
                        else        bidx  <= bidx + 7'd1;
                    end
                end
            endcase
        end
    end

    // R9: a stalled byte holds its value
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

    // R9: valid never drops inside a packet
    p_no_gap_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && !out_last |=> out_valid);

    // R8: at most one packet source is served per boundary
    p_one_grant_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({take_cs, take_cfg, take_restart, launch}));

    // R1: packet lengths stay between header-only and a full 64-byte packet
    p_plen_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> desc.plen >= 7'd4 && desc.plen <= 7'd64);

endmodule

// File: rtl/rsp_packetizer.sv
module rsp_packetizer
    import rsp_pkt_pkg::*;
#(
    parameter int          MAX_WR   = 298,
    parameter int          MAX_RD   = 298,
    parameter logic [15:0] FEATURES = 16'h0001,
    localparam int         ADDRW    = $clog2(MAX_RD)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             res_valid,
    input  logic [15:0]      res_status,
    input  logic [15:0]      res_len,
    output logic [ADDRW-1:0] rd_addr,
    input  logic [7:0]       rd_data,
    input  logic             cmd_valid,
    input  logic [15:0]      cmd_id,
    input  logic [15:0]      cmd_arg,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_last,
    input  logic             out_ready,
    output logic             cs_active
);

    logic        cs_req, cfg_req, restart_req, abandon;
    logic [15:0] cs_status;
    logic        take_cs, take_cfg, take_restart, launch, done;
    logic        active, first;
    logic [15:0] off, status, chunk;

    rsp_cmd_decode u_dec (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_id      (cmd_id),
        .cmd_arg     (cmd_arg),
        .res_valid   (res_valid),
        .take_cs     (take_cs),
        .take_cfg    (take_cfg),
        .take_restart(take_restart),
        .cs_req      (cs_req),
        .cfg_req     (cfg_req),
        .restart_req (restart_req),
        .abandon     (abandon),
        .cs_status   (cs_status),
        .cs_active   (cs_active)
    );

    rsp_track #(.MAX_RD(MAX_RD)) u_trk (
        .clk          (clk),
        .rst          (rst),
        .res_valid    (res_valid),
        .res_status   (res_status),
        .res_len      (res_len),
        .abandon      (abandon),
        .apply_restart(take_restart),
        .launch       (launch),
        .done         (done),
        .active       (active),
        .first        (first),
        .off          (off),
        .status       (status),
        .chunk        (chunk)
    );

    rsp_emit #(
        .MAX_WR  (MAX_WR),
        .MAX_RD  (MAX_RD),
        .FEATURES(FEATURES),
        .ADDRW   (ADDRW)
    ) u_emit (
        .clk         (clk),
        .rst         (rst),
        .cs_req      (cs_req),
        .cfg_req     (cfg_req),
        .restart_req (restart_req),
        .cs_status   (cs_status),
        .active      (active),
        .first       (first),
        .off         (off),
        .status      (status),
        .chunk       (chunk),
        .out_ready   (out_ready),
        .rd_data     (rd_data),
        .take_cs     (take_cs),
        .take_cfg    (take_cfg),
        .take_restart(take_restart),
        .launch      (launch),
        .done        (done),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_last    (out_last),
        .rd_addr     (rd_addr)
    );

endmodule

// File: tb/sim_rsp_packetizer.sv
module sim_rsp_packetizer;

    localparam int MAXRD = 298;
    localparam int AW    = $clog2(MAXRD);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          res_valid = 1'b0;
    logic [15:0]   res_status = '0;
    logic [15:0]   res_len = '0;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;
    logic          cmd_valid = 1'b0;
    logic [15:0]   cmd_id = '0;
    logic [15:0]   cmd_arg = '0;
    logic          out_valid;
    logic [7:0]    out_data;
    logic          out_last;
    logic          out_ready = 1'b1;
    logic          cs_active;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit stall_en = 1'b0;
    logic [7:0] got [64];
    int got_n;
    logic [7:0] expv [64];
    int exp_n;

    always #5 clk = ~clk;

    function automatic logic [7:0] mem(input int a);
        return 8'((a * 13 + 7) & 255);
    endfunction

    assign rd_data = mem(int'(rd_addr));

    rsp_packetizer u0 (
        .clk(clk), .rst(rst), .res_valid(res_valid), .res_status(res_status),
        .res_len(res_len), .rd_addr(rd_addr), .rd_data(rd_data),
        .cmd_valid(cmd_valid), .cmd_id(cmd_id), .cmd_arg(cmd_arg),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_ready(out_ready), .cs_active(cs_active)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, got %0d cycles exp < 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic send_cmd(input logic [15:0] id, input logic [15:0] arg);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_id = id; cmd_arg = arg;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send_res(input logic [15:0] st, input int len);
        @(negedge clk);
        res_valid = 1'b1; res_status = st; res_len = 16'(len);
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic cap_pkt();
        bit fin;
        fin = 1'b0;
        got_n = 0;
        while (!fin) begin
            @(negedge clk);
            out_ready = stall_en ? ((cyc % 5) != 3) : 1'b1;
            if (out_valid && out_ready) begin
                if (got_n < 64) got[got_n] = out_data;
                got_n++;
                if (out_last) fin = 1'b1;
            end
        end
    endtask

    task automatic check_pkt(input string tag);
        int bad;
        bad = -1;
        tests++;
        for (int k = 0; k < exp_n && k < 64; k++)
            if (bad < 0 && (k >= got_n || got[k] !== expv[k])) bad = k;
        if (got_n != exp_n) begin
            fails++;
            $display("FAIL %s: packet length got %0d exp %0d", tag, got_n, exp_n);
        end else if (bad >= 0) begin
            fails++;
            $display("FAIL %s: byte %0d got %02h exp %02h", tag, bad, got[bad], expv[bad]);
        end
    endtask

    task automatic mk_resp(input bit isfirst, input logic [15:0] field, input int off, input int ch);
        expv[0] = isfirst ? 8'h05 : 8'h06;
        expv[1] = 8'h00;
        expv[2] = field[7:0];
        expv[3] = field[15:8];
        for (int k = 0; k < ch; k++) expv[4 + k] = mem(off + k);
        exp_n = 4 + ch;
    endtask

    task automatic mk_small(input logic [7:0] b0, input logic [7:0] b2, input logic [7:0] b3);
        expv[0] = b0; expv[1] = 8'h00; expv[2] = b2; expv[3] = b3;
        exp_n = 4;
    endtask

    task automatic mk_cfg();
        expv[0] = 8'h01; expv[1] = 8'h00;
        expv[2] = 8'h2A; expv[3] = 8'h01;
        expv[4] = 8'h2A; expv[5] = 8'h01;
        expv[6] = 8'h01; expv[7] = 8'h00;
        exp_n = 8;
    endtask

    // captures and checks the packets of a full response, opening one included
    task automatic run_resp(input string tag, input logic [15:0] st, input int len);
        int eff, off, ch;
        bit fst;
        eff = (st != 0) ? 0 : ((len > MAXRD) ? MAXRD : len);
        off = 0;
        fst = 1'b1;
        do begin
            ch = ((eff - off) > 60) ? 60 : (eff - off);
            mk_resp(fst, fst ? st : 16'(off), off, ch);
            cap_pkt();
            check_pkt(tag);
            off += ch;
            fst = 1'b0;
        end while (off < eff);
    endtask

    task automatic idle_chk(input string tag, input int n);
        bit bad;
        bad = 1'b0;
        out_ready = 1'b1;
        repeat (n) begin
            @(negedge clk);
            if (out_valid) bad = 1'b1;
        end
        tests++;
        if (bad) begin
            fails++;
            $display("FAIL %s: out_valid got 1 exp 0 while idle", tag);
        end
    endtask

    task automatic chk_cs(input string tag, input logic expc);
        tests++;
        if (cs_active !== expc) begin
            fails++;
            $display("FAIL %s: cs_active got %0b exp %0b", tag, cs_active, expc);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        tests++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R11: out_valid got %0b exp 0 in reset", out_valid);
        end
        rst = 1'b0;
        chk_cs("R11 cs after reset", 1'b0);
        idle_chk("R11 nothing pending", 20);

        // R6: configuration reply
        send_cmd(16'd0, 16'd0);
        mk_cfg(); cap_pkt(); check_pkt("R6 config");

        // R7: chip-select actions
        send_cmd(16'd7, 16'd1);
        mk_small(8'h08, 8'h00, 8'h00); cap_pkt(); check_pkt("R7 cs assert reply");
        chk_cs("R7 cs asserted", 1'b1);
        send_cmd(16'd7, 16'd5);
        mk_small(8'h08, 8'h01, 8'h00); cap_pkt(); check_pkt("R7 cs bad action reply");
        chk_cs("R7 cs unchanged on bad action", 1'b1);
        send_cmd(16'd7, 16'd0);
        mk_small(8'h08, 8'h00, 8'h00); cap_pkt(); check_pkt("R7 cs deassert reply");
        chk_cs("R7 cs deasserted", 1'b0);

        // R1 R2 R9: every read length 0..130, stalls on odd lengths
        for (int len = 0; len <= 130; len++) begin
            stall_en = len[0];
            send_res(16'd0, len);
            run_resp("R1/R2 sweep", 16'd0, len);
        end
        stall_en = 1'b1;
        send_res(16'd0, MAXRD);
        run_resp("R2 full buffer", 16'd0, MAXRD);
        send_res(16'h0000, 400);
        run_resp("R2 clamp oversize", 16'd0, 400);

        // R3: error status drops the payload
        send_res(16'h0003, 100);
        run_resp("R3 error status", 16'h0003, 100);
        idle_chk("R3 nothing after error start", 150);

        // R4: replay after a finished response
        send_res(16'd0, 100);
        run_resp("R4 first pass", 16'd0, 100);
        send_cmd(16'd4, 16'd0);
        run_resp("R4 replay", 16'd0, 100);

        // R4: replay requested during the opening packet
        send_res(16'd0, 100);
        fork
            begin
                mk_resp(1'b1, 16'd0, 0, 60); cap_pkt(); check_pkt("R4 mid opening");
            end
            begin
                repeat (8) @(negedge clk);
                send_cmd(16'd4, 16'd0);
            end
        join
        run_resp("R4 mid replay", 16'd0, 100);
        idle_chk("R4 done after replay", 150);

        // R8: chip-select reply before config reply before continuation
        send_res(16'd0, 100);
        fork
            begin
                mk_resp(1'b1, 16'd0, 0, 60); cap_pkt(); check_pkt("R8 opening");
            end
            begin
                repeat (8) @(negedge clk);
                send_cmd(16'd0, 16'd0);
                send_cmd(16'd7, 16'd1);
            end
        join
        mk_small(8'h08, 8'h00, 8'h00); cap_pkt(); check_pkt("R8 cs first");
        mk_cfg(); cap_pkt(); check_pkt("R8 config second");
        mk_resp(1'b0, 16'd60, 60, 40); cap_pkt(); check_pkt("R8 continuation last");
        chk_cs("R8 cs asserted", 1'b1);

        // R5: abandon during the opening packet, later replay ignored
        send_res(16'd0, 200);
        fork
            begin
                mk_resp(1'b1, 16'd0, 0, 60); cap_pkt(); check_pkt("R5 packet in flight");
            end
            begin
                repeat (8) @(negedge clk);
                send_cmd(16'd2, 16'd0);
            end
        join
        idle_chk("R5 abandoned", 200);
        send_cmd(16'd4, 16'd0);
        idle_chk("R4 replay ignored after abandon", 150);

        // R10: new result during a response
        send_res(16'd0, 200);
        fork
            begin
                mk_resp(1'b1, 16'd0, 0, 60); cap_pkt(); check_pkt("R10 old opening");
            end
            begin
                repeat (8) @(negedge clk);
                send_res(16'd0, 30);
            end
        join
        run_resp("R10 new response", 16'd0, 30);
        idle_chk("R10 old response dropped", 150);

        // R12: unknown identifiers
        send_cmd(16'd9, 16'd1);
        send_cmd(16'd3, 16'd0);
        send_cmd(16'd5, 16'd0);
        idle_chk("R12 unknown ids", 100);
        chk_cs("R12 cs unchanged", 1'b1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule